// File: doc/BRIEF.md
# Multi-Mode PWM Time-Base Counter

This block is the timing core of a pulse-width modulator channel. A 16-bit counter advances on a prescaled clock-enable and runs in one of three count modes: rising sawtooth, falling sawtooth, or triangle. It can also be held. The counter's limit and four compare thresholds are double-buffered. Software writes land in shadow copies, and the active copies take them over only when the counter comes back to zero, so a waveform cycle never sees a half-updated threshold.

Each time the counter takes a new value, the block raises one-clock strobes for three cases: the value is zero, the value equals the active limit, or the value equals any of the four thresholds. A direction flag tells a downstream waveform stage whether a threshold match happened on the rising or the falling slope. Several instances can be aligned in two ways. One instance emits a sync-out strobe at zero. The others take a sync-in pulse that loads a programmed phase value into the counter and, in triangle mode, a programmed direction.

Top module: `pwm_timebase`

## Requirements
- R1: The counter advances only on a tick. A tick comes once every 2^(H+C) clocks, where H is control bits [4:2] and C is control bits [7:5], each from 0 to 7. A loaded sync-in restarts the tick spacing from that clock.
- R2: Mode 0 (control bits [1:0]) counts up. On a tick, a value at or above the active limit goes to 0, and any other value goes up by 1. The direction flag is 1.
- R3: Mode 1 counts down. On a tick, 0 reloads the active limit, and any other value goes down by 1. The direction flag is 0.
- R4: Mode 2 counts up to the active limit and then back down to 0, repeatedly. The direction flag drops to 0 on the tick that reaches the limit and rises to 1 on the tick that reaches 0.
- R5: Mode 3 holds the counter: ticks do not change it.
- R6: The write port decodes address 0 as control, 1 as the limit, and 2 to 5 as thresholds A to D; addresses 6 and 7 are ignored. Limit and threshold writes go to shadow copies. The shadow copies move to the active copies on the tick that brings the counter to 0.
- R7: With control bit 11 set, limit and threshold writes also update the active copies on the same edge. Control writes always take effect on the next edge.
- R8: zero_o and prd_o pulse for one clock, in the clock after the counter takes a new value equal to 0 or to the active limit.
- R9: cmp_o[i] pulses for one clock, in the clock after the counter takes a new value equal to active threshold i. In mode 2 this happens once per slope, and dir_o tells which slope.
- R10: sync_o copies zero_o when control bit 10 is set, and stays low otherwise.
- R11: With control bit 8 set, a sync_i pulse loads phase_i into the counter on the next edge. In mode 2 the same pulse loads control bit 9 into the direction flag.
- R12: With control bit 8 clear, sync_i has no effect.
- R13: After reset the counter, every register and every strobe read 0, the mode is 0 and dir_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | 16 | Register write data |
| sync_i | input | 1 | Sync-in pulse |
| phase_i | input | 16 | Phase value loaded on sync-in |
| cnt_o | output | 16 | Counter value |
| dir_o | output | 1 | Count direction, 1 = rising |
| zero_o | output | 1 | Counter reached zero |
| prd_o | output | 1 | Counter reached the active limit |
| cmp_o | output | 4 | Threshold match strobes, A at bit 0 |
| sync_o | output | 1 | Sync-out strobe |

## Verification
A broken prescaler, mode decode or turnaround shows up on cnt_o on the first tick after the fault, so it is one tick away at most. A shadow copy that is transferred at the wrong time stays hidden until the counter next passes the limit or a threshold. The first wrong or missing strobe on prd_o or cmp_o then marks the cycle, and with the small limits the bench uses that is within a few ticks. A wrong direction flag in triangle mode shows on dir_o at the turnaround tick itself. A wrong phase load shows on cnt_o on the clock right after the sync pulse.

// File: rtl/ptb_pkg.sv
package ptb_pkg;
  localparam int unsigned CTRL_W = 12;

  typedef enum logic [1:0] {
    MODE_UP   = 2'd0,
    MODE_DOWN = 2'd1,
    MODE_UPDN = 2'd2,
    MODE_HOLD = 2'd3
  } cnt_mode_e;

  typedef struct packed {
    logic      immediate;
    logic      sync_out_en;
    logic      sync_dir;
    logic      phase_en;
    logic [2:0] ck_log;
    logic [2:0] hs_log;
    cnt_mode_e mode;
  } ctrl_t;

  localparam int unsigned ADDR_CTRL = 0;
  localparam int unsigned ADDR_PRD  = 1;
  localparam int unsigned ADDR_CMP0 = 2;
endpackage

// File: rtl/ptb_regs.sv
module ptb_regs
  import ptb_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned N_CMP  = 4,
  parameter int unsigned ADDR_W = 3
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            wr_en_i,
  input  logic [ADDR_W-1:0]               wr_addr_i,
  input  logic [CNT_W-1:0]                wr_data_i,
  input  logic                            load_i,
  output ctrl_t                           ctrl_o,
  output logic [CNT_W-1:0]                prd_o,
  output logic [N_CMP-1:0][CNT_W-1:0]     cmp_o
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ADDR_CTRL);
  localparam logic [ADDR_W-1:0] A_PRD  = ADDR_W'(ADDR_PRD);

  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] prd_sh_q, prd_act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else if (wr_en_i && wr_addr_i == A_CTRL) ctrl_q <= ctrl_t'(wr_data_i[CTRL_W-1:0]);
  end

  // Direct write in immediate mode wins over the zero-point transfer
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prd_sh_q  <= '0;
      prd_act_q <= '0;
    end else begin
      if (wr_en_i && wr_addr_i == A_PRD) prd_sh_q <= wr_data_i;
      if (wr_en_i && wr_addr_i == A_PRD && ctrl_q.immediate) prd_act_q <= wr_data_i;
      else if (load_i) prd_act_q <= prd_sh_q;
    end
  end

  for (genvar i = 0; i < N_CMP; i++) begin : g_cmp
    localparam logic [ADDR_W-1:0] A_SLOT = ADDR_W'(ADDR_CMP0 + i);
    logic [CNT_W-1:0] sh_q, act_q;
    logic             hit;
    assign hit = wr_en_i && wr_addr_i == A_SLOT;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sh_q  <= '0;
        act_q <= '0;
      end else begin
        if (hit) sh_q <= wr_data_i;
        if (hit && ctrl_q.immediate) act_q <= wr_data_i;
        else if (load_i) act_q <= sh_q;
      end
    end
    assign cmp_o[i] = act_q;
  end

  assign ctrl_o = ctrl_q;
  assign prd_o  = prd_act_q;
endmodule

// File: rtl/ptb_prescale.sv
module ptb_prescale #(
  parameter int unsigned LOG_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LOG_W-1:0] hs_log_i,
  input  logic [LOG_W-1:0] ck_log_i,
  input  logic             clr_i,
  output logic             tick_o
);
  localparam int unsigned PS_W = 2 * ((1 << LOG_W) - 1);
  localparam int unsigned SH_W = LOG_W + 1;

  logic [PS_W-1:0] pc_q, limit;
  logic [SH_W-1:0] shift;

  assign shift  = SH_W'(hs_log_i) + SH_W'(ck_log_i);
  assign limit  = ~({PS_W{1'b1}} << shift);
  // >= so a divider shrink mid-count does not stall until wraparound
  assign tick_o = pc_q >= limit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else if (clr_i || tick_o) pc_q <= '0;
    else pc_q <= pc_q + 1'b1;
  end
endmodule

// File: rtl/ptb_counter.sv
module ptb_counter
  import ptb_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             sync_ld_i,
  input  logic [CNT_W-1:0] phase_i,
  input  logic             sync_dir_i,
  input  cnt_mode_e        mode_i,
  input  logic [CNT_W-1:0] prd_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             dir_o,
  output logic             fresh_o,
  output logic             load_o
);
  logic [CNT_W-1:0] cnt_q, nxt, inc, dec;
  logic             dir_q, dir_n, fresh_q, adv, sync_dir_n;

  assign inc = cnt_q + 1'b1;
  assign dec = cnt_q - 1'b1;
  assign adv = tick_i && (mode_i != MODE_HOLD);

  always_comb begin
    nxt   = cnt_q;
    dir_n = dir_q;
    unique case (mode_i)
      MODE_UP: begin
        nxt   = (cnt_q >= prd_i) ? '0 : inc;
        dir_n = 1'b1;
      end
      MODE_DOWN: begin
        nxt   = (cnt_q == '0) ? prd_i : dec;
        dir_n = 1'b0;
      end
      MODE_UPDN: begin
        if (dir_q) begin
          if (cnt_q < prd_i) begin
            nxt   = inc;
            dir_n = (inc != prd_i);
          end else begin
            nxt   = (cnt_q == '0) ? '0 : dec;
            dir_n = (nxt == '0);
          end
        end else if (cnt_q != '0) begin
          nxt   = dec;
          dir_n = (dec == '0);
        end else begin
          nxt   = (prd_i == '0) ? '0 : CNT_W'(1);
          dir_n = (prd_i != CNT_W'(1));
        end
      end
      default: begin
        nxt   = cnt_q;
        dir_n = dir_q;
      end
    endcase
  end

  always_comb begin
    unique case (mode_i)
      MODE_UPDN: sync_dir_n = sync_dir_i;
      MODE_UP:   sync_dir_n = 1'b1;
      MODE_DOWN: sync_dir_n = 1'b0;
      default:   sync_dir_n = dir_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      dir_q   <= 1'b1;
      fresh_q <= 1'b0;
    end else begin
      if (sync_ld_i) begin
        cnt_q <= phase_i;
        dir_q <= sync_dir_n;
      end else if (adv) begin
        cnt_q <= nxt;
        dir_q <= dir_n;
      end
      fresh_q <= sync_ld_i || adv;
    end
  end

  assign load_o  = adv && !sync_ld_i && (nxt == '0);
  assign cnt_o   = cnt_q;
  assign dir_o   = dir_q;
  assign fresh_o = fresh_q;
endmodule

// File: rtl/ptb_events.sv
module ptb_events #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned N_CMP = 4
) (
  input  logic                        fresh_i,
  input  logic [CNT_W-1:0]            cnt_i,
  input  logic [CNT_W-1:0]            prd_i,
  input  logic [N_CMP-1:0][CNT_W-1:0] cmp_i,
  input  logic                        sync_out_en_i,
  output logic                        zero_o,
  output logic                        prd_o,
  output logic [N_CMP-1:0]            cmp_o,
  output logic                        sync_o
);
  assign zero_o = fresh_i && (cnt_i == '0);
  assign prd_o  = fresh_i && (cnt_i == prd_i);
  assign sync_o = zero_o && sync_out_en_i;

  for (genvar i = 0; i < N_CMP; i++) begin : g_hit
    assign cmp_o[i] = fresh_i && (cnt_i == cmp_i[i]);
  end
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import ptb_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned N_CMP  = 4,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  input  logic              sync_i,
  input  logic [CNT_W-1:0]  phase_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              dir_o,
  output logic              zero_o,
  output logic              prd_o,
  output logic [N_CMP-1:0]  cmp_o,
  output logic              sync_o
);
  ctrl_t                       ctrl;
  logic [CNT_W-1:0]            prd_act;
  logic [N_CMP-1:0][CNT_W-1:0] cmp_act;
  logic                        tick, sync_ld, load_evt, fresh;

  assign sync_ld = sync_i && ctrl.phase_en;

  ptb_regs #(.CNT_W(CNT_W), .N_CMP(N_CMP), .ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .load_i (load_evt),
    .ctrl_o (ctrl),
    .prd_o  (prd_act),
    .cmp_o  (cmp_act)
  );

  ptb_prescale #(.LOG_W(3)) u_presc (
    .clk_i, .rst_ni,
    .hs_log_i (ctrl.hs_log),
    .ck_log_i (ctrl.ck_log),
    .clr_i    (sync_ld),
    .tick_o   (tick)
  );

  ptb_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni,
    .tick_i     (tick),
    .sync_ld_i  (sync_ld),
    .phase_i,
    .sync_dir_i (ctrl.sync_dir),
    .mode_i     (ctrl.mode),
    .prd_i      (prd_act),
    .cnt_o,
    .dir_o,
    .fresh_o    (fresh),
    .load_o     (load_evt)
  );

  ptb_events #(.CNT_W(CNT_W), .N_CMP(N_CMP)) u_evt (
    .fresh_i       (fresh),
    .cnt_i         (cnt_o),
    .prd_i         (prd_act),
    .cmp_i         (cmp_act),
    .sync_out_en_i (ctrl.sync_out_en),
    .zero_o,
    .prd_o,
    .cmp_o,
    .sync_o
  );
endmodule

// File: rtl/pwm_timebase_chk.sv
module pwm_timebase_chk
  import ptb_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sync_i,
  input logic [CNT_W-1:0] phase_i,
  input logic [CNT_W-1:0] cnt_o,
  input logic             zero_o,
  input logic             sync_o,
  input logic             tick,
  input logic             sync_ld,
  input logic             load_evt,
  input ctrl_t            ctrl,
  input logic [CNT_W-1:0] prd_act
);
  assert_up_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl.mode == MODE_UP && tick && !sync_ld && cnt_o >= prd_act) |=> (cnt_o == '0));

  assert_down_reload_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl.mode == MODE_DOWN && tick && !sync_ld && cnt_o == '0) |=> (cnt_o == $past(prd_act)));

  assert_updn_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl.mode == MODE_UPDN && tick && !sync_ld && cnt_o <= prd_act) |=> (cnt_o <= $past(prd_act)));

  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl.mode == MODE_HOLD && !sync_ld) |=> $stable(cnt_o));

  assert_shadow_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl.immediate && !load_evt) |=> $stable(prd_act));

  assert_sync_out_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_o |-> (zero_o && cnt_o == '0));

  assert_phase_load_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_ld |=> (cnt_o == $past(phase_i)));

  assert_sync_ignored_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_i && !ctrl.phase_en && !tick) |=> $stable(cnt_o));
endmodule

bind pwm_timebase pwm_timebase_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .sync_i   (sync_i),
  .phase_i  (phase_i),
  .cnt_o    (cnt_o),
  .zero_o   (zero_o),
  .sync_o   (sync_o),
  .tick     (tick),
  .sync_ld  (sync_ld),
  .load_evt (load_evt),
  .ctrl     (ctrl),
  .prd_act  (prd_act)
);

// File: tb/pwm_timebase_tb.sv
module pwm_timebase_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr_en = 1'b0, sync = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0, phase = '0;
  logic [15:0] cnt;
  logic        dir, zero, prd_hit, sync_out;
  logic [3:0]  cmp;

  int    n_chk = 0, n_bad = 0;
  logic  chk_en = 1'b0;
  string cur_req = "R13";

  always #(CLK_P/2) clk = ~clk;

  pwm_timebase u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .sync_i(sync), .phase_i(phase),
    .cnt_o(cnt), .dir_o(dir), .zero_o(zero), .prd_o(prd_hit),
    .cmp_o(cmp), .sync_o(sync_out)
  );

  // Behavioural model of the requirements
  logic [11:0] m_ctrl;
  logic [13:0] m_pc, m_lim;
  logic [15:0] m_cnt, m_prd_sh, m_prd, m_nx;
  logic [15:0] m_cs [4];
  logic [15:0] m_ca [4];
  logic        m_dir, m_fresh, m_tk, m_sl, m_adv, m_ld, m_nd;
  logic [1:0]  m_md;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl <= '0; m_pc <= '0; m_cnt <= '0; m_dir <= 1'b1; m_fresh <= 1'b0;
      m_prd_sh <= '0; m_prd <= '0;
      for (int i = 0; i < 4; i++) begin m_cs[i] <= '0; m_ca[i] <= '0; end
    end else begin
      m_md  = m_ctrl[1:0];
      m_lim = 14'((32'd1 << (m_ctrl[4:2] + m_ctrl[7:5])) - 1);
      m_tk  = m_pc >= m_lim;
      m_sl  = sync && m_ctrl[8];
      m_adv = m_tk && m_md != 2'd3;
      m_nx  = m_cnt; m_nd = m_dir;
      case (m_md)
        2'd0: begin m_nx = (m_cnt >= m_prd) ? 16'd0 : m_cnt + 16'd1; m_nd = 1'b1; end
        2'd1: begin m_nx = (m_cnt == 0) ? m_prd : m_cnt - 16'd1; m_nd = 1'b0; end
        2'd2: begin
          if (m_dir && m_cnt < m_prd) begin m_nx = m_cnt + 16'd1; m_nd = (m_nx != m_prd); end
          else if (m_dir) begin m_nx = (m_cnt == 0) ? 16'd0 : m_cnt - 16'd1; m_nd = (m_nx == 0); end
          else if (m_cnt != 0) begin m_nx = m_cnt - 16'd1; m_nd = (m_nx == 0); end
          else begin m_nx = (m_prd == 0) ? 16'd0 : 16'd1; m_nd = (m_prd != 16'd1); end
        end
        default: ;
      endcase
      m_ld = m_adv && !m_sl && m_nx == 0;
      m_pc <= (m_sl || m_tk) ? 14'd0 : m_pc + 14'd1;
      if (m_sl) begin
        m_cnt <= phase;
        m_dir <= (m_md == 2'd2) ? m_ctrl[9] : (m_md == 2'd0) ? 1'b1 : (m_md == 2'd1) ? 1'b0 : m_dir;
      end else if (m_adv) begin
        m_cnt <= m_nx; m_dir <= m_nd;
      end
      m_fresh <= m_sl || m_adv;
      if (m_ld) begin
        m_prd <= m_prd_sh;
        for (int i = 0; i < 4; i++) m_ca[i] <= m_cs[i];
      end
      if (wr_en) begin
        if (wr_addr == 3'd0) m_ctrl <= wr_data[11:0];
        if (wr_addr == 3'd1) begin m_prd_sh <= wr_data; if (m_ctrl[11]) m_prd <= wr_data; end
        for (int i = 0; i < 4; i++)
          if (wr_addr == 3'(i + 2)) begin m_cs[i] <= wr_data; if (m_ctrl[11]) m_ca[i] <= wr_data; end
      end
    end
  end

  task automatic check(input logic ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  // Cycle-by-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (chk_en) begin
      logic [3:0] e_cmp;
      logic       e_zero;
      for (int i = 0; i < 4; i++) e_cmp[i] = m_fresh && m_cnt == m_ca[i];
      e_zero = m_fresh && m_cnt == 0;
      check(cnt == m_cnt, cur_req, "cnt_o", cnt, m_cnt);
      check(dir == m_dir, "R4", "dir_o", dir, m_dir);
      check(zero == e_zero, "R8", "zero_o", zero, e_zero);
      check(prd_hit == (m_fresh && m_cnt == m_prd), "R8", "prd_o", prd_hit, m_fresh && m_cnt == m_prd);
      check(cmp == e_cmp, "R9", "cmp_o", cmp, e_cmp);
      check(sync_out == (e_zero && m_ctrl[10]), "R10", "sync_o", sync_out, e_zero && m_ctrl[10]);
    end
  end

  function automatic logic [15:0] ctl(int md, int hs, int ck, bit ph, bit sd, bit so, bit imm);
    return 16'({imm, so, sd, ph, 3'(ck), 3'(hs), 2'(md)});
  endfunction

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_cnt(input logic [15:0] v);
    int guard = 0;
    while (cnt != v && guard < 5000) begin @(negedge clk); guard++; end
  endtask

  task automatic pulse_sync(input logic [15:0] ph);
    phase = ph; sync = 1'b1;
    @(negedge clk);
    sync = 1'b0;
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #(CLK_P * 190000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired in %s act=0 exp=1", cur_req);
    summary();
    $finish;
  end

  initial begin
    bit   seen;
    logic [15:0] held;
    run(3);
    // R13 reset state
    check(cnt == 0 && dir == 1'b1, "R13", "cnt/dir in reset", {cnt, dir}, 1);
    check(zero == 0 && prd_hit == 0 && cmp == 0 && sync_out == 0, "R13", "strobes in reset",
          {zero, prd_hit, cmp, sync_out}, 0);
    rst_n = 1'b1;
    chk_en = 1'b1;
    run(4);

    // Sweep modes R2 R3 R4, limits and dividers R1
    for (int md = 0; md < 3; md++) begin
      for (int p = 1; p <= 6; p++) begin
        for (int dv = 0; dv < 3; dv++) begin
          cur_req = (dv != 0) ? "R1" : (md == 0) ? "R2" : (md == 1) ? "R3" : "R4";
          wr(3'd0, ctl(md, dv, (dv == 2) ? 1 : 0, 0, 0, 1, 0));
          wr(3'd1, 16'(p));
          for (int i = 0; i < 4; i++) wr(3'(i + 2), 16'((i + (p >> 1)) % (p + 1)));
          run((2 * p + 3) * (1 << (dv == 2 ? 3 : dv)) * 2 + 4);
        end
      end
    end

    // R6: mid-cycle limit write stays in the shadow until zero
    cur_req = "R6";
    wr(3'd0, ctl(0, 0, 0, 0, 0, 0, 0));
    wr(3'd1, 16'd9);
    run(25);
    wait_cnt(16'd2);
    wr(3'd1, 16'd3);
    seen = 1'b0;
    for (int k = 0; k < 10; k++) begin @(negedge clk); if (cnt == 16'd7) seen = 1'b1; end
    check(seen, "R6", "old limit kept until zero", seen, 1);
    run(20);

    // R7: immediate load
    cur_req = "R7";
    wr(3'd0, ctl(0, 0, 0, 0, 0, 0, 1));
    wr(3'd1, 16'd9);
    run(20);
    wait_cnt(16'd5);
    wr(3'd1, 16'd2);
    @(negedge clk);
    check(cnt == 0, "R7", "wrap on new limit", cnt, 0);
    run(10);

    // R11: phase load with direction, then prescaler restart
    cur_req = "R11";
    wr(3'd0, ctl(2, 0, 0, 1, 0, 1, 0));
    wr(3'd1, 16'd8);
    run(30);
    pulse_sync(16'd5);
    check(cnt == 5 && dir == 1'b0, "R11", "phase/dir load", {cnt, dir}, {16'd5, 1'b0});
    @(negedge clk);
    check(cnt == 4, "R11", "falls after phase", cnt, 4);
    run(30);
    wr(3'd0, ctl(2, 2, 0, 1, 0, 1, 0));
    run(20);
    pulse_sync(16'd5);
    run(3);
    check(cnt == 5, "R11", "hold through divided tick", cnt, 5);
    run(1);
    check(cnt == 4, "R11", "first tick after restart", cnt, 4);
    run(40);

    // R12: sync ignored without phase enable
    cur_req = "R12";
    wr(3'd0, ctl(0, 0, 0, 0, 0, 0, 0));
    wr(3'd1, 16'd20);
    run(30);
    wait_cnt(16'd3);
    pulse_sync(16'd15);
    check(cnt == 4, "R12", "sync ignored", cnt, 4);
    run(10);

    // R5: hold mode
    cur_req = "R5";
    wr(3'd0, ctl(3, 0, 0, 0, 0, 0, 0));
    held = cnt;
    run(10);
    check(cnt == held, "R5", "counter held", cnt, held);

    chk_en = 1'b0;
    summary();
    $finish;
  end
endmodule